// File: doc/BRIEF.md
# ATM Cell Delineation Engine

This block locates 53-byte ATM cell boundaries in an octet-aligned byte stream. Each accepted byte is tested as a possible header check byte against a CRC-8 computed over the four bytes before it. A three-state search machine (Hunt, Presync, Sync) runs beside the data path with its own byte counter. The data-path boundary is held by a second modulo-53 counter, and the search machine moves it only while the data path is out of cell delineation.

The data path keeps its own loss-of-delineation hysteresis. Seven consecutive bad checks declare loss. Delta consecutive good checks clear it, and so does a boundary update from the search machine. Every byte of a cell that starts during loss is flagged for discard. A one-cycle change-of-delineation pulse marks an update that lands on a new boundary. Configuration inputs set Delta, the coset offset, a six-bit compare for streams whose two top check bits are scrambled, and exclusion of the first header byte from the check.

Top module: `atm_cell_delin`

## Requirements
- R1: After reset the search state is Hunt, loss of delineation (`ocd_o`) is 1, `cocd_o` is 0, and the first valid byte is marked as a cell start with `discard_o` high.
- R2: The check value is CRC-8 with polynomial x^8+x^2+x+1 and zero start over header bytes 0..3 in arrival order (bit 7 first), XORed with 0x55 when `coset_en_i` is 1. In Hunt a byte equal to that value for the four bytes before it moves the state to Presync. States are encoded Hunt=0, Presync=1, Sync=2.
- R3: In Presync the check is taken once per cell at byte offset 4. After Delta correct checks, counting the one that ended Hunt, the state moves to Sync. A Delta of 0 counts as 1, and with Delta of 1 Hunt goes straight to Sync.
- R4: One incorrect check in Presync or Sync returns the state to Hunt.
- R5: `ocd_o` rises after the check byte of the 7th consecutive data-path cell with an incorrect check.
- R6: `ocd_o` falls after the check byte of the Delta-th consecutive data-path cell with a correct check.
- R7: In Sync with `ocd_o` high, a correct check moves the data-path boundary to the search boundary and clears `ocd_o`. If the old data-path position of that byte was not offset 4, `cocd_o` pulses high for one cycle.
- R8: `soc_o` marks the first byte of each data-path cell. `discard_o` is high on every byte of a cell whose first byte arrived while `ocd_o` was high, and low otherwise.
- R9: With `hec6_i` set, only check bits 5:0 are compared, so a stream whose bits 7:6 are inverted still locks.
- R10: With `skip_first_i` set, header byte 0 is replaced by zero in the check.
- R11: With `coset_en_i` clear, no 0x55 offset is applied, and a stream carrying the offset does not lock.
- R12: Cycles with `valid_i` low change no state and raise no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Stream byte |
| delta_i | input | DELTA_W | Good-cell count for Presync exit and loss clear |
| coset_en_i | input | 1 | Apply 0x55 offset to the check value |
| skip_first_i | input | 1 | Exclude header byte 0 from the check |
| hec6_i | input | 1 | Compare check bits 5:0 only |
| state_o | output | 2 | Search state (Hunt=0, Presync=1, Sync=2) |
| soc_o | output | 1 | First byte of a data-path cell |
| ocd_o | output | 1 | Loss of cell delineation |
| cocd_o | output | 1 | One-cycle pulse on a moved boundary |
| discard_o | output | 1 | Current byte belongs to a discarded cell |

## Verification
The search machine's boundary update and the data path's own check evaluation can fall on the same byte. Both act at a check byte, and both can clear loss of delineation. The bench first aligns the two counters, so the update and the Delta-th good check coincide. This must clear loss without a change-of-delineation pulse. It then starts the stream three bytes off the data-path counter, so the update lands on data-path offset 7. There it must pulse `cocd_o`, clear `ocd_o` and move the next cell-start marker onto the true cell.

// File: rtl/atm_cd_pkg.sv
package atm_cd_pkg;
  localparam int CELL_LEN = 53;
  localparam int HDR_LEN  = 4;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_PRESYNC = 2'd1,
    ST_SYNC    = 2'd2
  } cd_state_e;

  // CRC-8, x^8+x^2+x+1, msb first
  function automatic logic [7:0] crc8_byte(input logic [7:0] c_in, input logic [7:0] d);
    logic [7:0] c;
    c = c_in ^ d;
    for (int b = 0; b < 8; b++) begin
      c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/atm_cd_hec_win.sv
module atm_cd_hec_win #(
  parameter int         HDR_LEN = 4,
  parameter logic [7:0] COSET   = 8'h55
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [7:0] byte_i,
  input  logic       coset_en_i,
  input  logic       skip_first_i,
  input  logic       hec6_i,
  output logic       hec_ok_o
);
  import atm_cd_pkg::*;

  localparam int FILL_W = $clog2(HDR_LEN + 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(HDR_LEN);

  // win_q[0] oldest, win_q[HDR_LEN-1] newest
  logic [HDR_LEN-1:0][7:0] win_q;
  logic [HDR_LEN-1:0][7:0] win_m;
  logic [FILL_W-1:0]       fill_q;
  logic [7:0]              crc_v, exp_v, diff_v, mask_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (valid_i) begin
      if (HDR_LEN > 1) win_q <= {byte_i, win_q[HDR_LEN-1:1]};
      else             win_q <= byte_i;
      if (fill_q != FILL_FULL) fill_q <= fill_q + 1'b1;
    end
  end

  for (genvar i = 0; i < HDR_LEN; i++) begin : g_mask
    if (i == 0) begin : g_first
      assign win_m[i] = skip_first_i ? 8'h00 : win_q[i];
    end else begin : g_rest
      assign win_m[i] = win_q[i];
    end
  end

  always_comb begin
    crc_v = 8'h00;
    for (int i = 0; i < HDR_LEN; i++) crc_v = crc8_byte(crc_v, win_m[i]);
    exp_v    = crc_v ^ (coset_en_i ? COSET : 8'h00);
    diff_v   = exp_v ^ byte_i;
    mask_v   = hec6_i ? 8'h3F : 8'hFF;
    hec_ok_o = (fill_q == FILL_FULL) && ((diff_v & mask_v) == 8'h00);
  end
endmodule

// File: rtl/atm_cd_hunt_fsm.sv
module atm_cd_hunt_fsm #(
  parameter int CELL_LEN = 53,
  parameter int HDR_LEN  = 4,
  parameter int DELTA_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               hec_ok_i,
  input  logic [DELTA_W-1:0] delta_i,
  input  logic               ocd_i,
  output logic [1:0]         state_o,
  output logic               upd_o
);
  import atm_cd_pkg::*;

  localparam int POS_W = $clog2(CELL_LEN);
  localparam logic [POS_W-1:0] HEC_POS   = POS_W'(HDR_LEN);
  localparam logic [POS_W-1:0] POS_AFTER = POS_W'(HDR_LEN + 1);
  localparam logic [POS_W-1:0] POS_LAST  = POS_W'(CELL_LEN - 1);

  cd_state_e          state_q, state_d;
  logic [POS_W-1:0]   pos_q, pos_d;
  logic [DELTA_W-1:0] cnt_q, cnt_d;
  logic [DELTA_W:0]   cnt_inc;
  logic               at_hec;

  assign at_hec  = (pos_q == HEC_POS);
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    cnt_d   = cnt_q;
    upd_o   = 1'b0;
    if (valid_i) begin
      pos_d = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
      unique case (state_q)
        ST_HUNT: begin
          if (hec_ok_i) begin
            pos_d   = POS_AFTER;
            cnt_d   = DELTA_W'(1);
            state_d = (delta_i <= DELTA_W'(1)) ? ST_SYNC : ST_PRESYNC;
          end
        end
        ST_PRESYNC: begin
          if (at_hec) begin
            if (!hec_ok_i) begin
              state_d = ST_HUNT;
            end else begin
              cnt_d = cnt_inc[DELTA_W-1:0];
              if (cnt_inc >= {1'b0, delta_i}) state_d = ST_SYNC;
            end
          end
        end
        ST_SYNC: begin
          if (at_hec) begin
            if (!hec_ok_i)  state_d = ST_HUNT;
            else if (ocd_i) upd_o   = 1'b1;
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      pos_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/atm_cd_dp_track.sv
module atm_cd_dp_track #(
  parameter int CELL_LEN = 53,
  parameter int HDR_LEN  = 4,
  parameter int DELTA_W  = 4,
  parameter int OCD_BAD  = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               hec_ok_i,
  input  logic [DELTA_W-1:0] delta_i,
  input  logic               upd_i,
  output logic               soc_o,
  output logic               discard_o,
  output logic               ocd_o,
  output logic               cocd_o
);
  localparam int POS_W = $clog2(CELL_LEN);
  localparam int BAD_W = $clog2(OCD_BAD + 1);
  localparam logic [POS_W-1:0]   HEC_POS   = POS_W'(HDR_LEN);
  localparam logic [POS_W-1:0]   POS_AFTER = POS_W'(HDR_LEN + 1);
  localparam logic [POS_W-1:0]   POS_LAST  = POS_W'(CELL_LEN - 1);
  localparam logic [BAD_W-1:0]   BAD_LIM   = BAD_W'(OCD_BAD);
  localparam logic [DELTA_W-1:0] GOOD_MAX  = '1;

  logic [POS_W-1:0]   pos_q, pos_d;
  logic [BAD_W-1:0]   bad_q, bad_d;
  logic [DELTA_W-1:0] good_q, good_d;
  logic [DELTA_W:0]   good_inc;
  logic               ocd_q, ocd_d, cocd_q, cocd_d, disc_q, disc_d;

  assign soc_o    = valid_i && (pos_q == '0);
  assign good_inc = {1'b0, good_q} + 1'b1;

  always_comb begin
    pos_d  = pos_q;
    bad_d  = bad_q;
    good_d = good_q;
    ocd_d  = ocd_q;
    disc_d = disc_q;
    cocd_d = 1'b0;
    if (valid_i) begin
      if (soc_o) disc_d = ocd_q;
      if (upd_i) begin
        pos_d  = POS_AFTER;
        ocd_d  = 1'b0;
        cocd_d = (pos_q != HEC_POS);
        bad_d  = '0;
        good_d = '0;
      end else begin
        pos_d = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
        if (pos_q == HEC_POS) begin
          if (hec_ok_i) begin
            bad_d = '0;
            if (good_q != GOOD_MAX) good_d = good_inc[DELTA_W-1:0];
            if (ocd_q && (good_inc >= {1'b0, delta_i})) ocd_d = 1'b0;
          end else begin
            good_d = '0;
            if (bad_q != BAD_LIM) bad_d = bad_q + 1'b1;
            if ((bad_q + 1'b1) >= BAD_LIM) ocd_d = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      bad_q  <= '0;
      good_q <= '0;
      ocd_q  <= 1'b1;
      cocd_q <= 1'b0;
      disc_q <= 1'b1;
    end else begin
      pos_q  <= pos_d;
      bad_q  <= bad_d;
      good_q <= good_d;
      ocd_q  <= ocd_d;
      cocd_q <= cocd_d;
      disc_q <= disc_d;
    end
  end

  // a cell's fate is fixed at its first byte
  assign discard_o = valid_i && (soc_o ? ocd_q : disc_q);
  assign ocd_o     = ocd_q;
  assign cocd_o    = cocd_q;
endmodule

// File: rtl/atm_cell_delin.sv
module atm_cell_delin #(
  parameter int         CELL_LEN = atm_cd_pkg::CELL_LEN,
  parameter int         HDR_LEN  = atm_cd_pkg::HDR_LEN,
  parameter int         DELTA_W  = 4,
  parameter int         OCD_BAD  = 7,
  parameter logic [7:0] COSET    = 8'h55
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [7:0]         byte_i,
  input  logic [DELTA_W-1:0] delta_i,
  input  logic               coset_en_i,
  input  logic               skip_first_i,
  input  logic               hec6_i,
  output logic [1:0]         state_o,
  output logic               soc_o,
  output logic               ocd_o,
  output logic               cocd_o,
  output logic               discard_o
);
  logic               hec_ok, upd, ocd;
  logic [DELTA_W-1:0] delta_eff;

  assign delta_eff = (delta_i == '0) ? DELTA_W'(1) : delta_i;

  atm_cd_hec_win #(.HDR_LEN(HDR_LEN), .COSET(COSET)) u_win (
    .clk_i, .rst_ni, .valid_i, .byte_i,
    .coset_en_i, .skip_first_i, .hec6_i,
    .hec_ok_o (hec_ok)
  );

  atm_cd_hunt_fsm #(.CELL_LEN(CELL_LEN), .HDR_LEN(HDR_LEN), .DELTA_W(DELTA_W)) u_fsm (
    .clk_i, .rst_ni, .valid_i,
    .hec_ok_i (hec_ok),
    .delta_i  (delta_eff),
    .ocd_i    (ocd),
    .state_o,
    .upd_o    (upd)
  );

  atm_cd_dp_track #(.CELL_LEN(CELL_LEN), .HDR_LEN(HDR_LEN), .DELTA_W(DELTA_W),
                    .OCD_BAD(OCD_BAD)) u_dp (
    .clk_i, .rst_ni, .valid_i,
    .hec_ok_i (hec_ok),
    .delta_i  (delta_eff),
    .upd_i    (upd),
    .soc_o, .discard_o,
    .ocd_o    (ocd),
    .cocd_o
  );

  assign ocd_o = ocd;
endmodule

// File: rtl/atm_cd_chk.sv
module atm_cd_chk #(
  parameter int DELTA_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [DELTA_W-1:0] delta_i,
  input logic [1:0]         state_o,
  input logic               ocd_o,
  input logic               cocd_o
);
  assert_state_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd3);

  assert_no_early_sync_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && delta_i > DELTA_W'(1)) |=> state_o != 2'd2);

  assert_sync_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2) |=> state_o != 2'd1);

  assert_ocd_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ocd_o) |-> $past(valid_i));

  assert_ocd_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ocd_o) |-> $past(valid_i));

  assert_cocd_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cocd_o |=> !cocd_o);

  assert_cocd_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cocd_o |-> !ocd_o);

  assert_idle_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(state_o) && $stable(ocd_o) && !cocd_o));
endmodule

bind atm_cell_delin atm_cd_chk #(.DELTA_W(DELTA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .delta_i (delta_i),
  .state_o (state_o),
  .ocd_o   (ocd_o),
  .cocd_o  (cocd_o)
);

// File: tb/sim_atm_cell_delin.sv
module sim_atm_cell_delin;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [3:0] delta;
    logic       c_coset, c_h6, c_skip;
    logic       s_coset, s_flip, s_skip, gap;
    logic [3:0] k;
    logic [1:0] st;
    logic       ocd;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{4'd8, 1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0, 1'b0, 4'd8, 2'd2, 1'b0},
    '{4'd8, 1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0, 1'b1, 4'd7, 2'd1, 1'b1},
    '{4'd4, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b0, 4'd4, 2'd2, 1'b0},
    '{4'd4, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b1, 4'd3, 2'd1, 1'b1},
    '{4'd1, 1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0, 1'b0, 4'd1, 2'd2, 1'b0},
    '{4'd0, 1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0, 1'b0, 4'd1, 2'd2, 1'b0},
    '{4'd6, 1'b1,1'b1,1'b0, 1'b1,1'b1,1'b0, 1'b0, 4'd6, 2'd2, 1'b0},
    '{4'd8, 1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0, 1'b0, 4'd1, 2'd0, 1'b1},
    '{4'd5, 1'b1,1'b0,1'b1, 1'b1,1'b0,1'b1, 1'b1, 4'd5, 2'd2, 1'b0},
    '{4'd5, 1'b1,1'b0,1'b0, 1'b1,1'b0,1'b1, 1'b0, 4'd1, 2'd0, 1'b1},
    '{4'd2, 1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b0, 4'd1, 2'd0, 1'b1}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic [3:0] delta_i = 4'd8;
  logic       coset_en_i = 1'b1, skip_first_i = 1'b0, hec6_i = 1'b0;
  logic [1:0] state_o;
  logic       soc_o, ocd_o, cocd_o, discard_o;

  int n_chk = 0, n_err = 0, cocd_cnt = 0;
  logic soc_s, disc_s, hsoc, hdisc;

  always #(CLK_P/2) clk_i = ~clk_i;

  atm_cell_delin u0 (
    .clk_i, .rst_ni, .valid_i, .byte_i, .delta_i,
    .coset_en_i, .skip_first_i, .hec6_i,
    .state_o, .soc_o, .ocd_o, .cocd_o, .discard_o
  );

  always @(negedge clk_i) if (rst_ni && cocd_o) cocd_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hec_of(input logic [31:0] hdr, input bit skip, input bit coset);
    logic [7:0] c = 8'h00;
    logic fb;
    if (skip) hdr[31:24] = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      fb = c[7] ^ hdr[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return coset ? (c ^ 8'h55) : c;
  endfunction

  task automatic do_reset(input logic [3:0] d, input bit cs, input bit h6, input bit sk);
    valid_i = 1'b0;
    rst_ni  = 1'b0;
    delta_i = d; coset_en_i = cs; hec6_i = h6; skip_first_i = sk;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni   = 1'b1;
    cocd_cnt = 0;
    #1;
  endtask

  task automatic drive(input logic [7:0] b, input bit gap);
    @(negedge clk_i);
    byte_i  = b;
    valid_i = 1'b1;
    #1;
    soc_s  = soc_o;
    disc_s = discard_o;
    @(posedge clk_i);
    #1;
    valid_i = 1'b0;
    if (gap) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic send_hdr(input logic [31:0] hdr, input logic [7:0] hx,
                          input bit skip, input bit coset, input bit gap);
    logic [7:0] h;
    h = hec_of(hdr, skip, coset) ^ hx;
    for (int i = 3; i >= 0; i--) begin
      drive(hdr[8*i +: 8], gap);
      if (i == 3) begin hsoc = soc_s; hdisc = disc_s; end
    end
    drive(h, gap);
  endtask

  task automatic send_pay(input int n, input logic [7:0] v, input bit gap);
    for (int i = 0; i < n; i++) drive(v, gap);
  endtask

  function automatic logic [31:0] hdr_of(input int c, input bit sk);
    return {(sk ? 8'hA5 : 8'h00), 8'h10, 8'(8'h20 + c), 8'h01};
  endfunction

  initial begin
    #(CLK_P * 150000);
    n_err++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    // vector table: R2 R3 R9 R10 R11 R12
    for (int v = 0; v < NV; v++) begin
      do_reset(TBL[v].delta, TBL[v].c_coset, TBL[v].c_h6, TBL[v].c_skip);
      for (int c = 1; c <= int'(TBL[v].k); c++) begin
        send_hdr(hdr_of(c, TBL[v].s_skip), TBL[v].s_flip ? 8'hC0 : 8'h00,
                 TBL[v].s_skip, TBL[v].s_coset, TBL[v].gap);
        if (c < int'(TBL[v].k)) send_pay(48, 8'h6A, TBL[v].gap);
      end
      chk($sformatf("R3 R9 R10 R11 R12 state row%0d", v), state_o, TBL[v].st);
      chk($sformatf("R6 ocd row%0d", v), ocd_o, TBL[v].ocd);
      chk($sformatf("R7 no cocd aligned row%0d", v), cocd_cnt, 0);
    end

    // R1 reset state
    do_reset(4'd8, 1'b1, 1'b0, 1'b0);
    chk("R1 state", state_o, 0);
    chk("R1 ocd", ocd_o, 1);
    chk("R1 cocd", cocd_o, 0);
    drive(8'h00, 1'b0);
    chk("R1 soc first byte", soc_s, 1);
    chk("R8 discard first byte", disc_s, 1);

    // R4 Presync failure
    do_reset(4'd8, 1'b1, 1'b0, 1'b0);
    for (int c = 1; c <= 2; c++) begin
      send_hdr(hdr_of(c, 0), 8'h00, 0, 1, 0);
      send_pay(48, 8'h6A, 0);
    end
    chk("R3 presync after 2", state_o, 1);
    send_hdr(hdr_of(3, 0), 8'h01, 0, 1, 0);
    chk("R4 presync bad to hunt", state_o, 0);

    // R5 R6 R4 R8 loss hysteresis
    do_reset(4'd4, 1'b1, 1'b0, 1'b0);
    for (int c = 1; c <= 4; c++) begin
      send_hdr(hdr_of(c, 0), 8'h00, 0, 1, 0);
      send_pay(48, 8'h00, 0);
    end
    chk("R3 sync delta4", state_o, 2);
    chk("R6 ocd clear delta4", ocd_o, 0);
    for (int c = 1; c <= 7; c++) begin
      send_hdr(hdr_of(c, 0), 8'h01, 0, 1, 0);
      if (c == 1) chk("R4 sync bad to hunt", state_o, 0);
      if (c == 6) chk("R5 ocd low after 6 bad", ocd_o, 0);
      if (c == 7) chk("R5 ocd high after 7 bad", ocd_o, 1);
      if (c < 7) send_pay(48, 8'h00, 0);
    end
    drive(8'h00, 0);
    chk("R8 no discard in cell begun before loss", disc_s, 0);
    send_pay(47, 8'h00, 0);
    for (int c = 1; c <= 4; c++) begin
      send_hdr(hdr_of(c, 0), 8'h00, 0, 1, 0);
      if (c == 1) begin
        chk("R8 soc on cell start", hsoc, 1);
        chk("R8 discard on cell begun in loss", hdisc, 1);
      end
      if (c == 3) chk("R6 ocd held after 3 good", ocd_o, 1);
      if (c == 4) chk("R6 ocd cleared after 4 good", ocd_o, 0);
      send_pay(48, 8'h00, 0);
    end
    chk("R7 no cocd when aligned", cocd_cnt, 0);

    // R7 boundary move with cocd
    do_reset(4'd4, 1'b1, 1'b0, 1'b0);
    send_pay(3, 8'h00, 0);
    for (int c = 1; c <= 4; c++) begin
      send_hdr(32'h0000_0001, 8'h00, 0, 1, 0);
      send_pay(48, 8'h00, 0);
    end
    chk("R3 sync on shifted stream", state_o, 2);
    chk("R7 ocd still set before update", ocd_o, 1);
    send_hdr(32'h0000_0001, 8'h00, 0, 1, 0);
    chk("R7 cocd pulse", cocd_o, 1);
    chk("R7 ocd cleared by update", ocd_o, 0);
    drive(8'h00, 0);
    chk("R7 cocd one cycle", cocd_o, 0);
    send_pay(47, 8'h00, 0);
    send_hdr(32'h0000_0001, 8'h00, 0, 1, 0);
    chk("R7 soc on moved boundary", hsoc, 1);
    chk("R8 no discard after update", hdisc, 0);
    chk("R7 single cocd", cocd_cnt, 1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule